// File: doc/BRIEF.md
# Drift-Trimmed Seconds Prescaler

This block turns a crystal-rate enable (nominally 32768 pulses per second) into a one-clock seconds tick for a calendar. Its counter advances only on the crystal enable. When it reaches the terminal count it emits a tick and restarts. The terminal count is TICKS_PER_SEC minus one.

Crystal error is trimmed once an hour. A signed 16-bit tick count is added to the prescaler. This happens in the second in which the calendar's seconds step from 0 to 1, at minute 0. Software writes the correction one byte at a time. The correction is used only when the auto-compensation input is high. A positive correction shortens that one second and a negative correction lengthens it. Each unit moves the clock by one crystal period per hour.

Top module: `drift_trim_prescaler`

## Requirements
- R1: After reset `sec_tick_o` is low and the counter is zero, so the first second lasts exactly TICKS_PER_SEC enables.
- R2: `sec_tick_o` is a single-clock pulse in the clock cycle after the enable that completes a second. Clock cycles without `tick_en_i` neither advance the count nor produce a tick, so a second lasts TICKS_PER_SEC enables whatever the gaps between them.
- R3: If a second ends while `sec_i == 0`, `min_i == 0` and `auto_comp_i == 1`, the next second lasts TICKS_PER_SEC minus the active correction C, in enables.
- R4: A negative correction lengthens that second. The most negative code 0x8000 (−32768) gives TICKS_PER_SEC + 32768 enables, with no wrap.
- R5: A positive correction shortens that second. A correction of TICKS_PER_SEC − 1 or more gives a one-enable second.
- R6: A second that ends with `sec_i != 0` or `min_i != 0` is followed by a nominal second.
- R7: With `auto_comp_i` low when the minute-0 second ends, the next second is nominal.
- R8: A write with `comp_sel_i = 0` stores the low byte. A write with `comp_sel_i = 1` stores the high byte and makes {high, stored low} the active correction. A low-byte write alone leaves the active correction unchanged.
- R9: The code 0x7FFF is reserved. Committing it makes the active correction zero.
- R10: The correction applies only to the one second after the minute-0 second. The second after that is nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Crystal-rate enable, one per crystal period |
| comp_wr_i | input | 1 | Correction byte write strobe |
| comp_sel_i | input | 1 | Byte select: 0 low byte, 1 high byte (commits) |
| comp_wdata_i | input | 8 | Correction byte data |
| auto_comp_i | input | 1 | Enables the hourly correction |
| sec_i | input | SEC_W | Calendar seconds, binary |
| min_i | input | SEC_W | Calendar minutes, binary |
| sec_tick_o | output | 1 | One-second tick pulse |

## Verification
The bench builds the block with TICKS_PER_SEC = 64, so that each second takes only 64 enables. At that setting a correction of ±10 yields visibly different second lengths. The full negative extreme runs in about 33 thousand cycles. Any correction of 63 or more reaches the one-enable floor, so the clamp case is covered. The 16-bit correction path, the reserved code and the byte-commit ordering are exercised exactly as in the default 32768 build.

// File: rtl/drift_trim_pkg.sv
package drift_trim_pkg;
  localparam int COMP_W = 16;
  localparam logic [COMP_W-1:0] COMP_RESERVED = 16'h7FFF;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/trim_comp_reg.sv
module trim_comp_reg
  import drift_trim_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     sel_i,
  input  logic [7:0]               wdata_i,
  output logic signed [COMP_W-1:0] comp_o
);
  logic [7:0]        lo_q;
  logic [COMP_W-1:0] comp_q;
  logic [COMP_W-1:0] raw;

  assign raw = {wdata_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      comp_q <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_LO) lo_q <= wdata_i;
      else comp_q <= (raw == COMP_RESERVED) ? '0 : raw;
    end
  end

  assign comp_o = $signed(comp_q);

  p_no_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_q != COMP_RESERVED);

  p_lo_no_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_LO) |=> $stable(comp_q));
endmodule

// File: rtl/trim_hour_detect.sv
module trim_hour_detect #(
  parameter int SEC_W = 6
) (
  input  logic             wrap_i,
  input  logic             en_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] min_i,
  output logic             apply_o
);
  // second 0 of minute 0 is ending: seconds step 0 -> 1
  assign apply_o = wrap_i && en_i && (sec_i == '0) && (min_i == '0);
endmodule

// File: rtl/trim_prescale_cnt.sv
module trim_prescale_cnt #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int COMP_W        = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     apply_i,
  input  logic signed [COMP_W-1:0] comp_i,
  output logic                     wrap_o,
  output logic                     tick_o
);
  localparam int TW    = $clog2(TICKS_PER_SEC);
  localparam int CNT_W = ((TW > COMP_W) ? TW : COMP_W) + 1;
  localparam logic signed [CNT_W-1:0] TERM = CNT_W'(TICKS_PER_SEC - 1);

  logic signed [CNT_W-1:0] cnt_q;
  logic signed [CNT_W-1:0] start;

  assign wrap_o = en_i && (cnt_q >= TERM);
  assign start  = apply_i ? {{(CNT_W-COMP_W){comp_i[COMP_W-1]}}, comp_i} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= wrap_o;
      if (wrap_o)    cnt_q <= start;
      else if (en_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_tick_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(en_i));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && !tick_o));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= TERM) || $past(apply_i));

  p_nominal_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !apply_i) |=> (cnt_q == '0));
endmodule

// File: rtl/drift_trim_prescaler.sv
module drift_trim_prescaler
  import drift_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_W         = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             comp_wr_i,
  input  logic             comp_sel_i,
  input  logic [7:0]       comp_wdata_i,
  input  logic             auto_comp_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] min_i,
  output logic             sec_tick_o
);
  logic signed [COMP_W-1:0] comp;
  logic                     wrap;
  logic                     apply;

  trim_comp_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (comp_wr_i),
    .sel_i   (comp_sel_i),
    .wdata_i (comp_wdata_i),
    .comp_o  (comp)
  );

  trim_hour_detect #(.SEC_W(SEC_W)) u_hour (
    .wrap_i  (wrap),
    .en_i    (auto_comp_i),
    .sec_i   (sec_i),
    .min_i   (min_i),
    .apply_o (apply)
  );

  trim_prescale_cnt #(.TICKS_PER_SEC(TICKS_PER_SEC), .COMP_W(COMP_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tick_en_i),
    .apply_i (apply),
    .comp_i  (comp),
    .wrap_o  (wrap),
    .tick_o  (sec_tick_o)
  );

  p_apply_on_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply |-> (wrap && sec_i == '0 && min_i == '0));

  p_tick_follows_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> sec_tick_o);
endmodule

// File: tb/sim_drift_trim_prescaler.sv
module sim_drift_trim_prescaler;
  localparam int TPS = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_en_i = 1'b0;
  logic       comp_wr_i = 1'b0;
  logic       comp_sel_i = 1'b0;
  logic [7:0] comp_wdata_i = '0;
  logic       auto_comp_i = 1'b0;
  logic [5:0] sec_i = '0;
  logic [5:0] min_i = 6'd7;
  logic       sec_tick_o;

  int n_run = 0;
  int n_fail = 0;

  drift_trim_prescaler #(.TICKS_PER_SEC(TPS), .SEC_W(6)) u0 (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts enables until the tick that ends the current second
  task automatic run_second(input bit gaps, output int n);
    bit e = 1'b0;
    n = 0;
    for (int i = 0; i < 100000; i++) begin
      e = gaps ? ~e : 1'b1;
      tick_en_i = e;
      @(negedge clk_i);
      if (e) n++;
      if (sec_tick_o) begin
        tick_en_i = 1'b0;
        return;
      end
    end
    tick_en_i = 1'b0;
    n = -1;
  endtask

  task automatic wr_byte(input bit sel, input logic [7:0] d);
    comp_wr_i = 1'b1; comp_sel_i = sel; comp_wdata_i = d;
    @(negedge clk_i);
    comp_wr_i = 1'b0;
  endtask

  task automatic wr_comp(input logic [15:0] v);
    wr_byte(1'b0, v[7:0]);
    wr_byte(1'b1, v[15:8]);
  endtask

  // minute-0 second, then corrected second, then nominal second
  task automatic hour_seq(input int exp, input string req);
    int n;
    sec_i = 6'd0; min_i = 6'd0;
    run_second(1'b0, n);
    check(n == TPS, "R6", n, TPS);
    sec_i = 6'd1;
    run_second(1'b0, n);
    check(n == exp, req, n, exp);
    sec_i = 6'd2;
    run_second(1'b0, n);
    check(n == TPS, "R10", n, TPS);
    min_i = 6'd7;
  endtask

  task automatic t_reset;
    int n;
    check(sec_tick_o == 1'b0, "R1", sec_tick_o, 0);
    run_second(1'b0, n);
    check(n == TPS, "R1", n, TPS);
  endtask

  task automatic t_nominal;
    int n;
    for (int k = 0; k < 2; k++) begin
      sec_i = 6'(k + 3);
      run_second(1'b0, n);
      check(n == TPS, "R2", n, TPS);
    end
    @(negedge clk_i);
    check(sec_tick_o == 1'b0, "R2 single pulse", sec_tick_o, 0);
  endtask

  task automatic t_gated;
    int n;
    run_second(1'b1, n);
    check(n == TPS, "R2 gated", n, TPS);
  endtask

  task automatic t_off_hour;
    int n;
    auto_comp_i = 1'b1;
    wr_comp(16'd10);
    sec_i = 6'd0; min_i = 6'd1;
    run_second(1'b0, n);
    run_second(1'b0, n);
    check(n == TPS, "R6 min!=0", n, TPS);
    sec_i = 6'd1; min_i = 6'd0;
    run_second(1'b0, n);
    run_second(1'b0, n);
    check(n == TPS, "R6 sec!=0", n, TPS);
    min_i = 6'd7;
  endtask

  task automatic t_pos;
    auto_comp_i = 1'b1;
    wr_comp(16'd10);
    hour_seq(TPS - 10, "R3");
    wr_comp(16'd32766);
    hour_seq(1, "R5");
  endtask

  task automatic t_neg;
    auto_comp_i = 1'b1;
    wr_comp(16'hFFF6);
    hour_seq(TPS + 10, "R4");
    wr_comp(16'h8000);
    hour_seq(TPS + 32768, "R4 extreme");
  endtask

  task automatic t_disabled;
    wr_comp(16'd10);
    auto_comp_i = 1'b0;
    hour_seq(TPS, "R7");
    auto_comp_i = 1'b1;
  endtask

  task automatic t_bytes;
    wr_comp(16'd10);
    wr_byte(1'b0, 8'h20);
    hour_seq(TPS - 10, "R8 lo only");
    wr_byte(1'b1, 8'h00);
    hour_seq(TPS - 32, "R8 commit");
  endtask

  task automatic t_reserved;
    wr_comp(16'd5);
    wr_comp(16'h7FFF);
    hour_seq(TPS, "R9");
  endtask

  initial begin
    #(8 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_nominal();
    t_gated();
    t_off_hour();
    t_pos();
    t_neg();
    t_disabled();
    t_bytes();
    t_reserved();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule